// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block holds one 32-bit word that tells software why the system last came out of reset. It also lets software ask for a fresh system reset. The top five bits carry the cause flags: a power-on flag, a software power-on request, a software externally-initiated reset request, a push-button power-on event and a push-button externally-initiated event. The lower 27 bits always read as zero. Each flag group follows its own write rule. The cause flags that hardware raises are cleared by writing a one to them. The two software request flags are set by writing a one to them, and writing a zero to them has no effect.

The block counts hardware reset events in a small saturating counter. The counter lets it tell the first reset after power-up from any later reset. Only a reset that arrives while the counter is zero reloads the word, and that reload leaves just the power-on flag set. A software power-on request clears the counter, so the next hardware reset is treated as a power-on reset again. Either software request, and either push-button pulse, raises a one-cycle system reset request on the clock edge that follows. Another unit acts on that request.

Top module: `rst_cause_reg`

## Requirements
- R1: The first hardware reset after power-up, when the counter is zero, loads the word with only bit 31 set (0x8000_0000). Bits 26:0 always read as 0, and writing ones to them has no effect.
- R2: Writing a one to bit 31, bit 28 or bit 27 clears that bit. Writing a zero leaves it unchanged.
- R3: Writing a one to bit 30 or bit 29 sets that bit. Writing a zero to them leaves them unchanged.
- R4: The word is reached only inside the 8-byte window at BASE_ADDR (0xF020) and only when address bit 2 is 1. A read of the word with address bit 2 at 0 returns 0, and a write there does nothing. Addresses outside the window are ignored.
- R5: A write with bit 30 set raises the reset request and clears the reset counter, so the next hardware reset reloads 0x8000_0000.
- R6: A write with bit 29 set and bit 30 clear raises the reset request and leaves the counter unchanged.
- R7: A hardware reset that arrives while the counter is non-zero leaves the word unchanged. Each reset event, taken as the rising edge of rst_i, advances the counter once.
- R8: A pulse on btn_por_i sets bit 28, and a pulse on btn_xir_i sets bit 27. Each pulse raises the reset request. If a button pulse and a clearing write arrive in the same cycle, the set wins.
- R9: The reset counter saturates at its largest value instead of wrapping to zero, so a long run of resets never looks like a power-on reset.
- R10: Read data is registered. It shows the word in the cycle after a read, and it is 0 in every cycle that does not follow a read of the word.
- R11: sys_rst_req_o is high for exactly the one cycle after each trigger. It is never high without a trigger, and it is held low while rst_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high hardware reset; its rising edge counts as one reset event |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (16) | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| btn_por_i | input | 1 | Push-button power-on reset pulse |
| btn_xir_i | input | 1 | Push-button externally-initiated reset pulse |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench writes all-ones, single-bit and zero patterns into the flag field. These patterns separate the clear-on-one bits from the set-on-one bits, and they show that the lower 27 bits stay zero. It then runs sequences of hardware resets after a software externally-initiated request, after a software power-on request, and after a long run with no request. These sequences show whether the counter was kept, cleared or saturated, which tells a wrapping counter apart from a saturating one. It also reaches the neighbouring word and addresses just outside the window, which shows that the decode rejects them.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int unsigned WORD_W = 32;

  // flag bit positions; software decodes these, so they are fixed
  localparam int unsigned POR_BIT     = 31;
  localparam int unsigned SW_POR_BIT  = 30;
  localparam int unsigned SW_XIR_BIT  = 29;
  localparam int unsigned BTN_POR_BIT = 28;
  localparam int unsigned BTN_XIR_BIT = 27;
  localparam int unsigned FLAG_LO     = 27;
  localparam int unsigned FLAG_W      = WORD_W - FLAG_LO;

  // masks over the 5-bit flag field (bit 0 of the field is word bit 27)
  localparam logic [FLAG_W-1:0] CLR_ON_ONE = 5'b10011;
  localparam logic [FLAG_W-1:0] SET_ON_ONE = 5'b01100;
  localparam logic [FLAG_W-1:0] POR_ONLY   = 5'b10000;
endpackage

// File: rtl/rst_cause_decode.sv
module rst_cause_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned TAG_W = ADDR_W - 3;
  localparam logic [TAG_W-1:0] BASE_TAG = TAG_W'(BASE_ADDR >> 3);

  logic unused_addr;
  assign unused_addr = ^addr_i[1:0];

  // R4: only the upper word of the 8-byte window holds the register
  assign hit_o = (addr_i[ADDR_W-1:3] == BASE_TAG) && addr_i[2];
endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_i,
  input  logic clr_i,
  output logic evt_o,
  output logic first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             rst_q = 1'b0;
  logic [CNT_W-1:0] cnt_q = '0;

  assign evt_o   = rst_i && !rst_q;
  assign first_o = evt_o && (cnt_q == '0);

  always_ff @(posedge clk) begin
    rst_q <= rst_i;
    if (evt_o) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
    end
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst_i)
    clr_i |=> (cnt_q == '0));

  // R7
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $past(rst_i) |-> !evt_o);
endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              rst_i,
  input  logic              evt_i,
  input  logic              first_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wflags_i,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              req_o,
  output logic              clr_cnt_o
);
  localparam int unsigned I_SWP = SW_POR_BIT - FLAG_LO;
  localparam int unsigned I_SWX = SW_XIR_BIT - FLAG_LO;
  localparam int unsigned I_BTP = BTN_POR_BIT - FLAG_LO;
  localparam int unsigned I_BTX = BTN_XIR_BIT - FLAG_LO;
  localparam int unsigned I_POR = POR_BIT - FLAG_LO;

  logic [FLAG_W-1:0] flags_q = '0;
  logic              req_q   = 1'b0;
  logic [FLAG_W-1:0] wval;
  logic [FLAG_W-1:0] btn_set;
  logic [FLAG_W-1:0] flags_nx;
  logic              sw_req;

  assign wval = wr_i ? wflags_i : '0;

  always_comb begin
    btn_set        = '0;
    btn_set[I_BTP] = btn_por_i;
    btn_set[I_BTX] = btn_xir_i;
  end

  // R2, R3, R8: clear first, then set; button set wins over a clear
  assign flags_nx  = (flags_q & ~(wval & CLR_ON_ONE)) | (wval & SET_ON_ONE) | btn_set;
  assign sw_req    = wval[I_SWP] || wval[I_SWX];
  assign clr_cnt_o = wval[I_SWP] && !rst_i;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      req_q <= 1'b0;
      if (first_i) flags_q <= POR_ONLY;
    end else begin
      flags_q <= flags_nx;
      req_q   <= sw_req || btn_por_i || btn_xir_i;
    end
  end

  assign flags_o = flags_q;
  assign req_o   = req_q;

  // R2
  w1c_por_chk: assert property (@(posedge clk) disable iff (rst_i)
    (wr_i && wflags_i[I_POR]) |=> !flags_q[I_POR]);

  // R3
  sw_por_keep_chk: assert property (@(posedge clk) disable iff (rst_i)
    flags_q[I_SWP] |=> flags_q[I_SWP]);

  // R8
  btn_por_set_chk: assert property (@(posedge clk) disable iff (rst_i)
    btn_por_i |=> flags_q[I_BTP]);

  // R8
  btn_xir_set_chk: assert property (@(posedge clk) disable iff (rst_i)
    btn_xir_i |=> flags_q[I_BTX]);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'hF020,
  parameter int unsigned CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic              sys_rst_req_o
);
  logic              hit;
  logic              evt;
  logic              first;
  logic              clr_cnt;
  logic [FLAG_W-1:0] flags;
  logic [31:0]       rdata_q = '0;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[FLAG_LO-1:0];

  rst_cause_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  rst_cause_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk     (clk),
    .rst_i   (rst_i),
    .clr_i   (clr_cnt),
    .evt_o   (evt),
    .first_o (first)
  );

  rst_cause_status u_stat (
    .clk       (clk),
    .rst_i     (rst_i),
    .evt_i     (evt),
    .first_i   (first),
    .wr_i      (wr_en_i && hit),
    .wflags_i  (wdata_i[WORD_W-1:FLAG_LO]),
    .btn_por_i (btn_por_i),
    .btn_xir_i (btn_xir_i),
    .flags_o   (flags),
    .req_o     (sys_rst_req_o),
    .clr_cnt_o (clr_cnt)
  );

  // R10: registered read, zero when idle or missed
  always_ff @(posedge clk) begin
    if (rst_i || !(rd_en_i && hit)) rdata_q <= '0;
    else                            rdata_q <= {flags, {FLAG_LO{1'b0}}};
  end

  assign rdata_o = rdata_q;

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst_i)
    rdata_o[FLAG_LO-1:0] == '0);

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst_i)
    !$past(rd_en_i) |-> (rdata_o == '0));

  // R11
  req_cause_chk: assert property (@(posedge clk) disable iff (rst_i)
    sys_rst_req_o |-> $past((wr_en_i && (wdata_i[30] || wdata_i[29])) || btn_por_i || btn_xir_i));
endmodule

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        btn_por = 1'b0;
  logic        btn_xir = 1'b0;
  logic        req;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_word = '0;

  localparam logic [15:0] A_REG  = 16'hF024;
  localparam logic [15:0] A_LOW  = 16'hF020;
  localparam logic [15:0] A_OUT  = 16'hF02C;

  always #4 clk = ~clk;

  rst_cause_reg #(.ADDR_W(16), .BASE_ADDR(16'hF020), .CNT_W(2)) dut_i (
    .clk           (clk),
    .rst_i         (rst),
    .wr_en_i       (wr_en),
    .rd_en_i       (rd_en),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .rdata_o       (rdata),
    .btn_por_i     (btn_por),
    .btn_xir_i     (btn_xir),
    .sys_rst_req_o (req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic exp_req, input string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    check({tag, " req"}, {31'b0, req}, {31'b0, exp_req});
    @(negedge clk);
    check("R11 req drops", {31'b0, req}, 32'b0);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic hw_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R11 req low in reset", {31'b0, req}, 32'b0);
    end
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_word = 32'h8000_0000;
    do_read(A_REG, exp_word, "R1 power-on load");
  endtask

  task automatic t_w1c();
    do_write(A_REG, 32'h0000_0000, 1'b0, "R2 zero write");
    do_read(A_REG, 32'h8000_0000, "R2 zero keeps bit31");
    do_write(A_REG, 32'h8000_0000, 1'b0, "R2 w1c");
    do_read(A_REG, 32'h0, "R2 bit31 cleared");
  endtask

  task automatic t_buttons();
    @(negedge clk); btn_por = 1'b1;
    @(negedge clk); btn_por = 1'b0;
    check("R8 btn por req", {31'b0, req}, 32'h1);
    @(negedge clk);
    check("R11 single cycle", {31'b0, req}, 32'h0);
    do_read(A_REG, 32'h1000_0000, "R8 bit28 set");
    @(negedge clk); btn_xir = 1'b1;
    @(negedge clk); btn_xir = 1'b0;
    check("R8 btn xir req", {31'b0, req}, 32'h1);
    do_read(A_REG, 32'h1800_0000, "R8 bit27 set");
    // clear and set of bit28 in the same cycle: set wins
    @(negedge clk);
    wr_en = 1'b1; addr = A_REG; wdata = 32'h1000_0000; btn_por = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; btn_por = 1'b0;
    do_read(A_REG, 32'h1800_0000, "R8 set wins over clear");
    do_write(A_REG, 32'h1000_0000, 1'b0, "R2 clear bit28");
    do_read(A_REG, 32'h0800_0000, "R2 bit28 cleared");
    do_write(A_REG, 32'h0800_0000, 1'b0, "R2 clear bit27");
    do_write(A_REG, 32'h07FF_FFFF, 1'b0, "R1 low bits write");
    do_read(A_REG, 32'h0, "R1 low bits read zero");
  endtask

  task automatic t_decode();
    do_write(A_LOW, 32'h6000_0000, 1'b0, "R4 low word write");
    do_read(A_LOW, 32'h0, "R4 low word reads zero");
    do_write(A_OUT, 32'h6000_0000, 1'b0, "R4 outside write");
    do_read(A_OUT, 32'h0, "R4 outside reads zero");
    do_read(A_REG, 32'h0, "R4 word untouched");
  endtask

  task automatic t_soft_xir();
    do_write(A_REG, 32'h2000_0000, 1'b1, "R6 soft xir");
    do_write(A_REG, 32'h0, 1'b0, "R3 zero write");
    do_read(A_REG, 32'h2000_0000, "R3 bit29 kept");
    hw_reset(2);
    do_read(A_REG, 32'h2000_0000, "R7 R6 later reset keeps word");
  endtask

  task automatic t_soft_por();
    do_write(A_REG, 32'h4000_0000, 1'b1, "R5 soft por");
    do_read(A_REG, 32'h6000_0000, "R3 bit30 set");
    hw_reset(1);
    do_read(A_REG, 32'h8000_0000, "R5 reload after soft por");
  endtask

  task automatic t_saturate();
    do_write(A_REG, 32'h8000_0000, 1'b0, "R2 clear before saturation");
    for (int i = 0; i < 4; i++) hw_reset(1);
    do_read(A_REG, 32'h0, "R9 counter does not wrap");
  endtask

  task automatic t_latency();
    do_write(A_REG, 32'hFFFF_FFFF, 1'b1, "R3 all ones");
    @(negedge clk);
    rd_en = 1'b1; addr = A_REG;
    @(negedge clk);
    rd_en = 1'b0;
    check("R10 data one cycle after read", rdata, 32'h6000_0000);
    @(negedge clk);
    check("R10 zero when idle", rdata, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_w1c();
        t_buttons();
        t_decode();
        t_soft_xir();
        t_soft_por();
        t_saturate();
        t_latency();
      end
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule